// File: doc/BRIEF.md
# Rename Backpressure Credit Tracker

This block decides, cycle by cycle, how much of an incoming rename group an out-of-order core may accept. For every hardware thread it holds the latest free-slot reports from four downstream structures: the reorder buffer, the issue queue, the load queue and the store queue. It also holds three counts of work renamed but not yet dispatched: all instructions, loads only, and stores only. Space is the last report minus the work still in transit. The work in transit is the stored count less what was dispatched this very cycle.

A rename group of up to `RW` slots is presented for one thread per cycle, with a load/store marking for each slot. If either the reorder buffer or the issue queue has no space, the whole group is refused and a cause is named. Otherwise slots are taken in order until the group ends, the reorder-buffer/issue-queue credit runs out, or a load (store) finds no load-queue (store-queue) room. Load and store room drop as slots earlier in the same group are taken. In parallel the block evaluates a prioritised stall condition for the stage's control logic. It keeps four saturating counters of refusals, one for each cause.

Top module: `rct_credit_tracker`

## Requirements
- R1: After reset every thread holds reported free counts equal to ROB_DEPTH, IQ_DEPTH, LQ_DEPTH and SQ_DEPTH. It also holds the reorder buffer marked empty, all in-transit counts at zero, and all four event counters at zero.
- R2: Space in a structure equals its effective report minus (stored in-transit count minus this cycle's dispatch count). Reorder buffer and issue queue use the total count with `disp_total`, the load queue uses the load count with `disp_ld`, and the store queue uses the store count with `disp_st`.
- R3: A report is used in the same cycle it arrives and is kept for the thread when its flag is set; otherwise the kept value is used. `rpt_iq_vld` covers the issue queue. `rpt_lsq_vld` covers load and store queues together. `rpt_rob_vld` covers the reorder-buffer count and its empty indication.
- R4: With `grp_cnt` nonzero and min(reorder-buffer space, issue-queue space) at most zero, `blocked` is 1 and `acc_cnt` is 0. `stop_why` is 1 when reorder-buffer space is the smaller or the two are equal, and 2 otherwise.
- R5: Slots are taken in order. A slot with its `grp_is_ld` bit set stops the group when load-queue space minus the loads already taken in this group is at most zero (`stop_why` 3). A slot with its `grp_is_st` bit set stops the group in the same way against store-queue space (`stop_why` 4). The load test comes before the store test. `stop_why` is 0 when nothing refused a slot.
- R6: At the clock edge the selected thread's total count becomes total minus `disp_total` plus `acc_cnt`. Its load and store counts change the same way with `disp_ld`/`disp_st` and the number of loads/stores taken.
- R7: `acc_cnt` never exceeds `grp_cnt` (itself at most RW), nor the smaller of reorder-buffer and issue-queue space.
- R8: `stall_why` is the first true condition in this order, and `stall` is 1 exactly when `stall_why` is nonzero. The conditions are: `ext_stall` (1); reorder-buffer space at most zero (2); issue-queue space at most zero (3); load-queue and store-queue space both at most zero (4); `reg_free_avail` low (5); `serialize_pend` with the effective reorder buffer not empty or the total count minus `disp_total` nonzero (6).
- R9: Each cycle in which `stop_why` is nonzero adds one to exactly one counter, chosen by the cause: `evt_rob` for 1, `evt_iq` for 2, `evt_lq` for 3, `evt_sq` for 4. A counter at all ones stays there.
- R10: Under dispatch counts that never exceed the matching in-transit counts, no in-transit count goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tid | input | TW | Thread served this cycle |
| grp_cnt | input | GW | Number of valid slots in the rename group (0..RW) |
| grp_is_ld | input | RW | Per-slot load marking |
| grp_is_st | input | RW | Per-slot store marking |
| rpt_iq_vld | input | 1 | Issue-queue report valid |
| rpt_iq_free | input | CW | Reported issue-queue free slots |
| rpt_lsq_vld | input | 1 | Load and store queue reports valid |
| rpt_lq_free | input | CW | Reported load-queue free slots |
| rpt_sq_free | input | CW | Reported store-queue free slots |
| rpt_rob_vld | input | 1 | Reorder-buffer report valid |
| rpt_rob_free | input | CW | Reported reorder-buffer free slots |
| rpt_rob_empty | input | 1 | Reported reorder-buffer empty indication |
| disp_total | input | GW | Instructions of this thread dispatched this cycle |
| disp_ld | input | GW | Loads dispatched into the load queue this cycle |
| disp_st | input | GW | Stores dispatched into the store queue this cycle |
| ext_stall | input | 1 | Stall request from a later stage |
| reg_free_avail | input | 1 | Physical registers available for renaming |
| serialize_pend | input | 1 | A serializing instruction waits for the back end to drain |
| acc_cnt | output | GW | Slots accepted this cycle |
| blocked | output | 1 | Whole group refused for lack of reorder-buffer or issue-queue space |
| stop_why | output | 3 | Refusal cause: 0 none, 1 reorder buffer, 2 issue queue, 3 load queue, 4 store queue |
| stall | output | 1 | Stage stall indication |
| stall_why | output | 3 | Stall cause code per R8 |
| evt_rob | output | EVT_W | Refusals caused by the reorder buffer |
| evt_iq | output | EVT_W | Refusals caused by the issue queue |
| evt_lq | output | EVT_W | Refusals caused by the load queue |
| evt_sq | output | EVT_W | Refusals caused by the store queue |

## Verification
Every cycle the bound checker confirms several relations. A refused group accepts nothing and names a reorder-buffer or issue-queue cause. The accept count stays within the group size and within the available credit. A load- or store-queue stop always leaves slots behind. An external stall always wins the stall priority. The event counters move by at most one, saturate, and never have two causes at once. The in-transit counts stay non-negative. Whether the arithmetic itself is right can only be shown by the bench's scenarios, which track a second model of the per-thread state: the same-cycle bypass of reports, the per-slot running room inside a group, the tie rule, the full stall priority sweep and counter saturation.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef enum logic [2:0] {
    STOP_NONE = 3'd0,
    STOP_ROB  = 3'd1,
    STOP_IQ   = 3'd2,
    STOP_LQ   = 3'd3,
    STOP_SQ   = 3'd4
  } stop_cause_e;

  typedef enum logic [2:0] {
    STL_NONE = 3'd0,
    STL_EXT  = 3'd1,
    STL_ROB  = 3'd2,
    STL_IQ   = 3'd3,
    STL_LSQ  = 3'd4,
    STL_REG  = 3'd5,
    STL_SER  = 3'd6
  } stall_cause_e;

  localparam int N_EVT   = 4;
  localparam int EVT_ROB = 0;
  localparam int EVT_IQ  = 1;
  localparam int EVT_LQ  = 2;
  localparam int EVT_SQ  = 3;

endpackage

// File: rtl/rct_event_ctr.sv
module rct_event_ctr #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [EVT_W-1:0] cnt
);
  localparam logic [EVT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + EVT_W'(1);
    end
  end
endmodule

// File: rtl/rct_thread_state.sv
module rct_thread_state #(
  parameter int NTHR      = 2,
  parameter int TW        = 1,
  parameter int CW        = 5,
  parameter int SW        = 7,
  parameter int ROB_DEPTH = 16,
  parameter int IQ_DEPTH  = 8,
  parameter int LQ_DEPTH  = 4,
  parameter int SQ_DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        sel,
  input  logic [CW-1:0]        nxt_rob,
  input  logic [CW-1:0]        nxt_iq,
  input  logic [CW-1:0]        nxt_lq,
  input  logic [CW-1:0]        nxt_sq,
  input  logic                 nxt_empty,
  input  logic signed [SW-1:0] nxt_tot,
  input  logic signed [SW-1:0] nxt_ld,
  input  logic signed [SW-1:0] nxt_st,
  output logic [CW-1:0]        cur_rob,
  output logic [CW-1:0]        cur_iq,
  output logic [CW-1:0]        cur_lq,
  output logic [CW-1:0]        cur_sq,
  output logic                 cur_empty,
  output logic signed [SW-1:0] cur_tot,
  output logic signed [SW-1:0] cur_ld,
  output logic signed [SW-1:0] cur_st
);
  logic [CW-1:0]        rob_a   [NTHR];
  logic [CW-1:0]        iq_a    [NTHR];
  logic [CW-1:0]        lq_a    [NTHR];
  logic [CW-1:0]        sq_a    [NTHR];
  logic                 empty_a [NTHR];
  logic signed [SW-1:0] tot_a   [NTHR];
  logic signed [SW-1:0] ld_a    [NTHR];
  logic signed [SW-1:0] st_a    [NTHR];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic                 hit;
    logic [CW-1:0]        rob_r, iq_r, lq_r, sq_r;
    logic                 empty_r;
    logic signed [SW-1:0] tot_r, ld_r, st_r;

    assign hit = (sel == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rob_r   <= CW'(ROB_DEPTH);
        iq_r    <= CW'(IQ_DEPTH);
        lq_r    <= CW'(LQ_DEPTH);
        sq_r    <= CW'(SQ_DEPTH);
        empty_r <= 1'b1;
        tot_r   <= '0;
        ld_r    <= '0;
        st_r    <= '0;
      end else if (hit) begin
        rob_r   <= nxt_rob;
        iq_r    <= nxt_iq;
        lq_r    <= nxt_lq;
        sq_r    <= nxt_sq;
        empty_r <= nxt_empty;
        tot_r   <= nxt_tot;
        ld_r    <= nxt_ld;
        st_r    <= nxt_st;
      end
    end

    assign rob_a[t]   = rob_r;
    assign iq_a[t]    = iq_r;
    assign lq_a[t]    = lq_r;
    assign sq_a[t]    = sq_r;
    assign empty_a[t] = empty_r;
    assign tot_a[t]   = tot_r;
    assign ld_a[t]    = ld_r;
    assign st_a[t]    = st_r;
  end

  always_comb begin
    cur_rob   = rob_a[0];
    cur_iq    = iq_a[0];
    cur_lq    = lq_a[0];
    cur_sq    = sq_a[0];
    cur_empty = empty_a[0];
    cur_tot   = tot_a[0];
    cur_ld    = ld_a[0];
    cur_st    = st_a[0];
    for (int t = 1; t < NTHR; t++) begin
      if (sel == TW'(t)) begin
        cur_rob   = rob_a[t];
        cur_iq    = iq_a[t];
        cur_lq    = lq_a[t];
        cur_sq    = sq_a[t];
        cur_empty = empty_a[t];
        cur_tot   = tot_a[t];
        cur_ld    = ld_a[t];
        cur_st    = st_a[t];
      end
    end
  end
endmodule

// File: rtl/rct_group_gate.sv
module rct_group_gate #(
  parameter int RW = 4,
  parameter int GW = 3,
  parameter int SW = 7
) (
  input  logic [GW-1:0]        grp_cnt,
  input  logic [RW-1:0]        is_ld,
  input  logic [RW-1:0]        is_st,
  input  logic signed [SW-1:0] cap,
  input  logic signed [SW-1:0] lq_room,
  input  logic signed [SW-1:0] sq_room,
  output logic [GW-1:0]        n_take,
  output logic [GW-1:0]        n_take_ld,
  output logic [GW-1:0]        n_take_st,
  output logic                 hit_lq,
  output logic                 hit_sq
);
  localparam logic signed [SW-1:0] ZERO = '0;

  logic [RW:0]          alive;
  logic signed [SW-1:0] ld_run [RW+1];
  logic signed [SW-1:0] st_run [RW+1];
  logic [GW-1:0]        cnt_run [RW+1];
  logic [GW-1:0]        cld_run [RW+1];
  logic [GW-1:0]        cst_run [RW+1];
  logic [RW-1:0]        lq_stop_v, sq_stop_v;

  assign alive[0]   = 1'b1;
  assign ld_run[0]  = '0;
  assign st_run[0]  = '0;
  assign cnt_run[0] = '0;
  assign cld_run[0] = '0;
  assign cst_run[0] = '0;

  for (genvar i = 0; i < RW; i++) begin : g_slot
    localparam logic [GW-1:0]        IDX  = GW'(i);
    localparam logic signed [SW-1:0] IDXS = SW'(i);
    logic want, ld_ok, st_ok, take, tld, tst;

    assign want  = (IDX < grp_cnt) && (cap > IDXS);
    assign ld_ok = !is_ld[i] || ((lq_room - ld_run[i]) > ZERO);
    assign st_ok = !is_st[i] || ((sq_room - st_run[i]) > ZERO);
    assign take  = alive[i] && want && ld_ok && st_ok;
    assign tld   = take && is_ld[i];
    assign tst   = take && is_st[i];

    assign lq_stop_v[i] = alive[i] && want && !ld_ok;
    assign sq_stop_v[i] = alive[i] && want && ld_ok && !st_ok;

    assign alive[i+1]   = take;
    assign ld_run[i+1]  = ld_run[i] + SW'(tld);
    assign st_run[i+1]  = st_run[i] + SW'(tst);
    assign cnt_run[i+1] = cnt_run[i] + GW'(take);
    assign cld_run[i+1] = cld_run[i] + GW'(tld);
    assign cst_run[i+1] = cst_run[i] + GW'(tst);
  end

  assign n_take    = cnt_run[RW];
  assign n_take_ld = cld_run[RW];
  assign n_take_st = cst_run[RW];
  assign hit_lq    = |lq_stop_v;
  assign hit_sq    = |sq_stop_v;
endmodule

// File: rtl/rct_stall_check.sv
module rct_stall_check #(
  parameter int SW = 7
) (
  input  logic                 ext_stall,
  input  logic signed [SW-1:0] rob_room,
  input  logic signed [SW-1:0] iq_room,
  input  logic signed [SW-1:0] lq_room,
  input  logic signed [SW-1:0] sq_room,
  input  logic                 reg_ok,
  input  logic                 ser_pend,
  input  logic                 rob_empty,
  input  logic signed [SW-1:0] in_transit,
  output logic                 stall,
  output logic [2:0]           why
);
  import rct_pkg::*;
  localparam logic signed [SW-1:0] ZERO = '0;

  stall_cause_e cause;

  always_comb begin
    if (ext_stall)                                   cause = STL_EXT;
    else if (rob_room <= ZERO)                       cause = STL_ROB;
    else if (iq_room <= ZERO)                        cause = STL_IQ;
    else if ((lq_room <= ZERO) && (sq_room <= ZERO)) cause = STL_LSQ;
    else if (!reg_ok)                                cause = STL_REG;
    else if (ser_pend && (!rob_empty || (in_transit != ZERO))) cause = STL_SER;
    else                                             cause = STL_NONE;
  end

  assign why   = cause;
  assign stall = (cause != STL_NONE);
endmodule

// File: rtl/rct_credit_tracker.sv
module rct_credit_tracker #(
  parameter int NTHR      = 2,
  parameter int RW        = 4,
  parameter int ROB_DEPTH = 16,
  parameter int IQ_DEPTH  = 8,
  parameter int LQ_DEPTH  = 4,
  parameter int SQ_DEPTH  = 4,
  parameter int EVT_W     = 8,
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int GW   = $clog2(RW + 1),
  localparam int MAXQ = (ROB_DEPTH > IQ_DEPTH ? ROB_DEPTH : IQ_DEPTH) >
                        (LQ_DEPTH > SQ_DEPTH ? LQ_DEPTH : SQ_DEPTH) ?
                        (ROB_DEPTH > IQ_DEPTH ? ROB_DEPTH : IQ_DEPTH) :
                        (LQ_DEPTH > SQ_DEPTH ? LQ_DEPTH : SQ_DEPTH),
  localparam int CW   = $clog2(MAXQ + 1),
  localparam int SW   = ((CW > GW) ? CW : GW) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tid,
  input  logic [GW-1:0]    grp_cnt,
  input  logic [RW-1:0]    grp_is_ld,
  input  logic [RW-1:0]    grp_is_st,
  input  logic             rpt_iq_vld,
  input  logic [CW-1:0]    rpt_iq_free,
  input  logic             rpt_lsq_vld,
  input  logic [CW-1:0]    rpt_lq_free,
  input  logic [CW-1:0]    rpt_sq_free,
  input  logic             rpt_rob_vld,
  input  logic [CW-1:0]    rpt_rob_free,
  input  logic             rpt_rob_empty,
  input  logic [GW-1:0]    disp_total,
  input  logic [GW-1:0]    disp_ld,
  input  logic [GW-1:0]    disp_st,
  input  logic             ext_stall,
  input  logic             reg_free_avail,
  input  logic             serialize_pend,
  output logic [GW-1:0]    acc_cnt,
  output logic             blocked,
  output logic [2:0]       stop_why,
  output logic             stall,
  output logic [2:0]       stall_why,
  output logic [EVT_W-1:0] evt_rob,
  output logic [EVT_W-1:0] evt_iq,
  output logic [EVT_W-1:0] evt_lq,
  output logic [EVT_W-1:0] evt_sq
);
  import rct_pkg::*;
  localparam logic signed [SW-1:0] ZERO = '0;

  // Space left: last report minus what is still in transit after this
  // cycle's dispatch.
  function automatic logic signed [SW-1:0] room_left(
    input logic [CW-1:0]        last,
    input logic signed [SW-1:0] pending,
    input logic [GW-1:0]        gone
  );
    logic signed [SW-1:0] l, g;
    l = SW'(last);
    g = SW'(gone);
    return l - (pending - g);
  endfunction

  // Counter after dispatch leaves and new work enters.
  function automatic logic signed [SW-1:0] pend_next(
    input logic signed [SW-1:0] pending,
    input logic [GW-1:0]        gone,
    input logic [GW-1:0]        added
  );
    logic signed [SW-1:0] g, a;
    g = SW'(gone);
    a = SW'(added);
    return pending - g + a;
  endfunction

  // Stored per-thread state
  logic [CW-1:0]        cur_rob, cur_iq, cur_lq, cur_sq;
  logic                 cur_empty;
  logic signed [SW-1:0] cur_tot, cur_ld, cur_st;

  // Effective reports (same-cycle bypass)
  logic [CW-1:0]        eff_rob, eff_iq, eff_lq, eff_sq;
  logic                 eff_empty;

  // Space and gating
  logic signed [SW-1:0] rob_free, iq_free, lq_free, sq_free;
  logic signed [SW-1:0] min_free, cap, remain_tot;
  logic                 rob_wins, gate_blk;
  logic [GW-1:0]        n_ld, n_st;
  logic                 hit_lq, hit_sq;
  logic signed [SW-1:0] nxt_tot, nxt_ld, nxt_st;
  stop_cause_e          stop_c;
  logic [N_EVT-1:0]     ev_inc;
  logic [EVT_W-1:0]     evt_all [N_EVT];

  assign eff_iq    = rpt_iq_vld  ? rpt_iq_free   : cur_iq;
  assign eff_lq    = rpt_lsq_vld ? rpt_lq_free   : cur_lq;
  assign eff_sq    = rpt_lsq_vld ? rpt_sq_free   : cur_sq;
  assign eff_rob   = rpt_rob_vld ? rpt_rob_free  : cur_rob;
  assign eff_empty = rpt_rob_vld ? rpt_rob_empty : cur_empty;

  assign rob_free = room_left(eff_rob, cur_tot, disp_total);
  assign iq_free  = room_left(eff_iq,  cur_tot, disp_total);
  assign lq_free  = room_left(eff_lq,  cur_ld,  disp_ld);
  assign sq_free  = room_left(eff_sq,  cur_st,  disp_st);

  assign rob_wins   = (rob_free <= iq_free);
  assign min_free   = rob_wins ? rob_free : iq_free;
  assign gate_blk   = (grp_cnt != '0) && (min_free <= ZERO);
  assign cap        = gate_blk ? ZERO : min_free;
  assign remain_tot = cur_tot - SW'(disp_total);

  rct_thread_state #(
    .NTHR(NTHR), .TW(TW), .CW(CW), .SW(SW),
    .ROB_DEPTH(ROB_DEPTH), .IQ_DEPTH(IQ_DEPTH),
    .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .sel(tid),
    .nxt_rob(eff_rob), .nxt_iq(eff_iq), .nxt_lq(eff_lq), .nxt_sq(eff_sq),
    .nxt_empty(eff_empty),
    .nxt_tot(nxt_tot), .nxt_ld(nxt_ld), .nxt_st(nxt_st),
    .cur_rob(cur_rob), .cur_iq(cur_iq), .cur_lq(cur_lq), .cur_sq(cur_sq),
    .cur_empty(cur_empty),
    .cur_tot(cur_tot), .cur_ld(cur_ld), .cur_st(cur_st)
  );

  rct_group_gate #(.RW(RW), .GW(GW), .SW(SW)) u_gate (
    .grp_cnt(grp_cnt), .is_ld(grp_is_ld), .is_st(grp_is_st),
    .cap(cap), .lq_room(lq_free), .sq_room(sq_free),
    .n_take(acc_cnt), .n_take_ld(n_ld), .n_take_st(n_st),
    .hit_lq(hit_lq), .hit_sq(hit_sq)
  );

  rct_stall_check #(.SW(SW)) u_stall (
    .ext_stall(ext_stall),
    .rob_room(rob_free), .iq_room(iq_free),
    .lq_room(lq_free), .sq_room(sq_free),
    .reg_ok(reg_free_avail), .ser_pend(serialize_pend),
    .rob_empty(eff_empty), .in_transit(remain_tot),
    .stall(stall), .why(stall_why)
  );

  assign nxt_tot = pend_next(cur_tot, disp_total, acc_cnt);
  assign nxt_ld  = pend_next(cur_ld,  disp_ld,    n_ld);
  assign nxt_st  = pend_next(cur_st,  disp_st,    n_st);

  always_comb begin
    if (gate_blk)    stop_c = rob_wins ? STOP_ROB : STOP_IQ;
    else if (hit_lq) stop_c = STOP_LQ;
    else if (hit_sq) stop_c = STOP_SQ;
    else             stop_c = STOP_NONE;
  end

  assign blocked  = gate_blk;
  assign stop_why = stop_c;

  assign ev_inc[EVT_ROB] = (stop_c == STOP_ROB);
  assign ev_inc[EVT_IQ]  = (stop_c == STOP_IQ);
  assign ev_inc[EVT_LQ]  = (stop_c == STOP_LQ);
  assign ev_inc[EVT_SQ]  = (stop_c == STOP_SQ);

  for (genvar k = 0; k < N_EVT; k++) begin : g_evt
    rct_event_ctr #(.EVT_W(EVT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc[k]), .cnt(evt_all[k])
    );
  end

  assign evt_rob = evt_all[EVT_ROB];
  assign evt_iq  = evt_all[EVT_IQ];
  assign evt_lq  = evt_all[EVT_LQ];
  assign evt_sq  = evt_all[EVT_SQ];
endmodule

// File: rtl/rct_credit_tracker_chk.sv
module rct_credit_tracker_chk #(
  parameter int RW    = 4,
  parameter int GW    = 3,
  parameter int SW    = 7,
  parameter int EVT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [GW-1:0]        grp_cnt,
  input logic [GW-1:0]        acc_cnt,
  input logic                 blocked,
  input logic [2:0]           stop_why,
  input logic                 ext_stall,
  input logic                 stall,
  input logic [2:0]           stall_why,
  input logic signed [SW-1:0] rob_free,
  input logic signed [SW-1:0] iq_free,
  input logic [3:0]           ev_inc,
  input logic [EVT_W-1:0]     evt_all [4],
  input logic signed [SW-1:0] nxt_tot,
  input logic signed [SW-1:0] nxt_ld,
  input logic signed [SW-1:0] nxt_st
);
  localparam logic [EVT_W-1:0] TOP = '1;
  logic signed [SW-1:0] acc_s;
  assign acc_s = SW'(acc_cnt);

  assert_block_no_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (acc_cnt == '0) && ((stop_why == 3'd1) || (stop_why == 3'd2)));

  assert_queue_stop_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_why == 3'd3) || (stop_why == 3'd4)) |-> (acc_cnt < grp_cnt) && !blocked);

  assert_accept_in_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt <= grp_cnt) && (acc_cnt <= GW'(RW)));

  assert_accept_in_credit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt != '0) |-> (rob_free >= acc_s) && (iq_free >= acc_s));

  assert_ext_stall_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_stall |-> stall && (stall_why == 3'd1));

  assert_single_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_inc));

  for (genvar k = 0; k < 4; k++) begin : g_evt_chk
    assert_evt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (evt_all[k] == $past(evt_all[k])) ||
               (evt_all[k] == $past(evt_all[k]) + EVT_W'(1)));
    assert_evt_hold_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_all[k] == TOP) |=> (evt_all[k] == TOP));
  end

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_tot[SW-1] && !nxt_ld[SW-1] && !nxt_st[SW-1]);
endmodule

bind rct_credit_tracker rct_credit_tracker_chk #(
  .RW(RW), .GW(GW), .SW(SW), .EVT_W(EVT_W)
) u_chk (.*);

// File: tb/tb_rct_credit_tracker.sv
module tb_rct_credit_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 2, RW = 4, ROBD = 16, IQD = 8, LQD = 4, SQD = 4;
  localparam int EVT_W = 8, TW = 1, GW = 3, CW = 5;
  localparam int EVT_MAX = (1 << EVT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] tid;
  logic [GW-1:0] grp_cnt, disp_total, disp_ld, disp_st;
  logic [RW-1:0] grp_is_ld, grp_is_st;
  logic rpt_iq_vld, rpt_lsq_vld, rpt_rob_vld, rpt_rob_empty;
  logic [CW-1:0] rpt_iq_free, rpt_lq_free, rpt_sq_free, rpt_rob_free;
  logic ext_stall, reg_free_avail, serialize_pend;
  logic [GW-1:0] acc_cnt;
  logic blocked, stall;
  logic [2:0] stop_why, stall_why;
  logic [EVT_W-1:0] evt_rob, evt_iq, evt_lq, evt_sq;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_rob[NTHR], m_iq[NTHR], m_lq[NTHR], m_sq[NTHR], m_tot[NTHR], m_ld[NTHR], m_st[NTHR];
  bit m_empty[NTHR];
  int m_evt[4];
  int got_acc, got_stop;

  always #(CLK_PERIOD/2) clk = ~clk;

  rct_credit_tracker #(.NTHR(NTHR), .RW(RW), .ROB_DEPTH(ROBD), .IQ_DEPTH(IQD),
    .LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .EVT_W(EVT_W)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    grp_cnt = 0; grp_is_ld = 0; grp_is_st = 0;
    rpt_iq_vld = 0; rpt_lsq_vld = 0; rpt_rob_vld = 0; rpt_rob_empty = 0;
    rpt_iq_free = 0; rpt_lq_free = 0; rpt_sq_free = 0; rpt_rob_free = 0;
    disp_total = 0; disp_ld = 0; disp_st = 0;
    ext_stall = 0; reg_free_avail = 1; serialize_pend = 0;
  endtask

  // One cycle: inputs already set after a falling edge.
  task automatic run_cycle();
    int t, erob, eiq, elq, esq, robf, iqf, lqf, sqf, mn, src, acc, nl, ns, stop, sw, rem;
    bit eemp, blk;
    #1;
    t = int'(tid);
    erob = rpt_rob_vld ? int'(rpt_rob_free) : m_rob[t];
    eemp = rpt_rob_vld ? rpt_rob_empty : m_empty[t];
    eiq  = rpt_iq_vld ? int'(rpt_iq_free) : m_iq[t];
    elq  = rpt_lsq_vld ? int'(rpt_lq_free) : m_lq[t];
    esq  = rpt_lsq_vld ? int'(rpt_sq_free) : m_sq[t];
    rem  = m_tot[t] - int'(disp_total);
    robf = erob - rem;
    iqf  = eiq - rem;
    lqf  = elq - (m_ld[t] - int'(disp_ld));
    sqf  = esq - (m_st[t] - int'(disp_st));
    src  = (iqf < robf) ? 2 : 1;
    mn   = (iqf < robf) ? iqf : robf;
    blk  = (grp_cnt != 0) && (mn <= 0);
    acc = 0; nl = 0; ns = 0; stop = 0;
    if (blk) stop = src;
    else begin
      for (int i = 0; i < int'(grp_cnt); i++) begin
        if (i >= mn) break;
        if (grp_is_ld[i] && (lqf - nl) <= 0) begin stop = 3; break; end
        if (grp_is_st[i] && (sqf - ns) <= 0) begin stop = 4; break; end
        acc++;
        if (grp_is_ld[i]) nl++;
        if (grp_is_st[i]) ns++;
      end
    end
    if (ext_stall) sw = 1;
    else if (robf <= 0) sw = 2;
    else if (iqf <= 0) sw = 3;
    else if (lqf <= 0 && sqf <= 0) sw = 4;
    else if (!reg_free_avail) sw = 5;
    else if (serialize_pend && (!eemp || rem != 0)) sw = 6;
    else sw = 0;
    got_acc = int'(acc_cnt);
    got_stop = int'(stop_why);
    chk("R2 R3 R5 R6 R7 acc_cnt", int'(acc_cnt), acc);
    chk("R4 blocked", int'(blocked), int'(blk));
    chk("R4 R5 stop_why", int'(stop_why), stop);
    chk("R8 stall_why", int'(stall_why), sw);
    chk("R8 stall", int'(stall), int'(sw != 0));
    chk("R9 evt_rob", int'(evt_rob), m_evt[0]);
    chk("R9 evt_iq", int'(evt_iq), m_evt[1]);
    chk("R9 evt_lq", int'(evt_lq), m_evt[2]);
    chk("R9 evt_sq", int'(evt_sq), m_evt[3]);
    @(posedge clk);
    m_rob[t] = erob; m_iq[t] = eiq; m_lq[t] = elq; m_sq[t] = esq; m_empty[t] = eemp;
    m_tot[t] = rem + acc;
    m_ld[t] = m_ld[t] - int'(disp_ld) + nl;
    m_st[t] = m_st[t] - int'(disp_st) + ns;
    if (stop != 0 && m_evt[stop-1] < EVT_MAX) m_evt[stop-1]++;
    chk("R10 in-transit non-negative", int'(m_tot[t] < 0 || m_ld[t] < 0 || m_st[t] < 0), 0);
    @(negedge clk);
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic rand_inputs();
    int t;
    quiet();
    t = int'($urandom % NTHR);
    tid = TW'(t);
    grp_cnt = GW'($urandom % (RW + 1));
    for (int i = 0; i < RW; i++) begin
      int k;
      k = int'($urandom % 4);
      grp_is_ld[i] = (k == 1);
      grp_is_st[i] = (k == 2);
    end
    rpt_iq_vld  = $urandom % 2 == 0;
    rpt_lsq_vld = $urandom % 2 == 0;
    rpt_rob_vld = $urandom % 2 == 0;
    rpt_rob_empty = $urandom % 2 == 0;
    rpt_rob_free = CW'($urandom % (ROBD + 1));
    rpt_iq_free  = CW'($urandom % (IQD + 1));
    rpt_lq_free  = CW'($urandom % (LQD + 1));
    rpt_sq_free  = CW'($urandom % (SQD + 1));
    disp_total = GW'($urandom % (min2(m_tot[t], RW) + 1));
    disp_ld    = GW'($urandom % (min2(m_ld[t], RW) + 1));
    disp_st    = GW'($urandom % (min2(m_st[t], RW) + 1));
    ext_stall = $urandom % 8 == 0;
    reg_free_avail = $urandom % 8 != 0;
    serialize_pend = $urandom % 4 == 0;
  endtask

  task automatic drain(input int t);
    while (m_tot[t] > 0 || m_ld[t] > 0 || m_st[t] > 0) begin
      quiet();
      tid = TW'(t);
      disp_total = GW'(min2(m_tot[t], RW));
      disp_ld    = GW'(min2(m_ld[t], RW));
      disp_st    = GW'(min2(m_st[t], RW));
      run_cycle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NTHR; t++) begin
      m_rob[t] = ROBD; m_iq[t] = IQD; m_lq[t] = LQD; m_sq[t] = SQD;
      m_empty[t] = 1; m_tot[t] = 0; m_ld[t] = 0; m_st[t] = 0;
    end
    for (int k = 0; k < 4; k++) m_evt[k] = 0;
    quiet();
    tid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state; serialize pending sees an empty, idle back end
    tid = 1; serialize_pend = 1;
    run_cycle();
    chk("R1 no stall after reset", int'(stall), 0);
    // R1: full-depth group of loads fits the reset load-queue depth
    quiet(); tid = 0; grp_cnt = GW'(RW); grp_is_ld = '1;
    run_cycle();
    chk("R1 reset load room", got_acc, LQD);
    drain(0);

    // R5: two loads of room inside a four-load group
    quiet(); tid = 0; rpt_lsq_vld = 1; rpt_lq_free = 2; rpt_sq_free = 4;
    grp_cnt = 4; grp_is_ld = '1;
    run_cycle();
    chk("R5 load room runs out in group", got_acc, 2);
    chk("R5 load-queue cause", got_stop, 3);
    drain(0);

    // R4: tie between reorder buffer and issue queue goes to the reorder buffer
    quiet(); tid = 1; rpt_rob_vld = 1; rpt_rob_free = 0; rpt_rob_empty = 1;
    rpt_iq_vld = 1; rpt_iq_free = 0; grp_cnt = 2;
    run_cycle();
    chk("R4 tie cause", got_stop, 1);
    quiet(); tid = 1; rpt_rob_vld = 1; rpt_rob_free = 3; rpt_rob_empty = 1;
    rpt_iq_vld = 1; rpt_iq_free = 1; grp_cnt = 3;
    run_cycle();
    chk("R7 credit caps accept", got_acc, 1);
    drain(1);

    // R8: sweep of all stall condition combinations on drained thread 1
    for (int c = 0; c < 128; c++) begin
      quiet(); tid = 1;
      ext_stall = c[0];
      rpt_rob_vld = 1; rpt_rob_free = c[1] ? 0 : 5; rpt_rob_empty = !c[6];
      rpt_iq_vld = 1;  rpt_iq_free  = c[2] ? 0 : 5;
      rpt_lsq_vld = 1; rpt_lq_free  = c[3] ? 0 : 3; rpt_sq_free = c[4] ? 0 : 3;
      reg_free_avail = !c[5];
      serialize_pend = 1;
      run_cycle();
    end

    // Mixed traffic over both threads
    for (int n = 0; n < 4000; n++) begin
      rand_inputs();
      run_cycle();
    end

    // R9: saturation of the reorder-buffer refusal counter
    drain(0);
    for (int n = 0; n < 300; n++) begin
      quiet(); tid = 0; rpt_rob_vld = 1; rpt_rob_free = 0; grp_cnt = 1;
      rpt_iq_vld = 1; rpt_iq_free = 5;
      run_cycle();
    end
    chk("R9 counter saturates", int'(evt_rob), EVT_MAX);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule